// File: doc/BRIEF.md
# Dual-Direction Storing Bus Transceiver

This block carries data both ways between two parallel ports, called A and B. Each direction has its own bank of storage, one cell per bit. Four local controls decide what that bank does:

- a latch enable;
- a local clock;
- an active-low clock qualifier;
- an active-low output enable.

With these controls a bank can pass data straight through, freeze it, capture it on a local clock rise, or capture it only when the qualifier allows. The B-to-A bank mirrors the A-to-B bank and uses its own set of controls.

The whole block runs on one system clock. The local latch-enable and local clock signals are treated as asynchronous levels. Each passes through a synchronizer that is `SYNC_STAGES` flops deep (default 2). A rise of the local clock is detected when the previous synchronized sample is 0 and the current one is 1.

The tri-state pins are modelled as two signals: a data output that always shows the stored word, and a drive flag. A deasserted drive flag stands for high impedance. The ports carry levels, not transfers, so there is no valid/ready handshake and no back-pressure. A receiver takes the data output whenever the drive flag is set.

Top module: `bus_xcvr_top`

## Requirements
- R1: On each system-clock edge where a direction's synchronized latch enable is 1, that bank loads the opposite-port input present at that edge, regardless of clock or qualifier. The new value appears on the data output after that edge. The latch enable reaches the bank two system-clock edges after it is applied (default `SYNC_STAGES` = 2).
- R2: When the synchronized latch enable is 0 and no local clock rise is detected, the bank keeps its value.
- R3: When the synchronized latch enable is 0, a detected local clock rise with the qualifier at 0 loads the opposite-port input. The qualifier and the input are sampled at the edge where the rise is detected.
- R4: When the qualifier is 1, a detected clock rise leaves the bank unchanged. The qualifier has no effect while the synchronized latch enable is 1.
- R5: A direction's drive flag equals the inverse of its output enable as sampled at the previous system-clock edge, whatever the other controls are doing.
- R6: The two directions are independent. Each uses only its own controls and its own source port, and both can store and drive at the same time.
- R7: While reset is 1, both banks read zero and both drive flags read 0.
- R8: After the latch enable falls, the bank holds the last value it took while transparent, until a qualified clock rise occurs.
- R9: Every bit of the `DATA_W`-wide path (default 18) behaves the same, so any bit pattern is carried intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | DATA_W | A-port data arriving (source for A-to-B) |
| b_in | input | DATA_W | B-port data arriving (source for B-to-A) |
| ab_le | input | 1 | A-to-B latch enable, asynchronous level |
| ab_clk | input | 1 | A-to-B local clock, asynchronous level |
| ab_ce_n | input | 1 | A-to-B clock qualifier, active low |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ba_le | input | 1 | B-to-A latch enable, asynchronous level |
| ba_clk | input | 1 | B-to-A local clock, asynchronous level |
| ba_ce_n | input | 1 | B-to-A clock qualifier, active low |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| b_out | output | DATA_W | Stored A-to-B word shown on the B side |
| b_drive | output | 1 | B side driven (0 means high impedance) |
| a_out | output | DATA_W | Stored B-to-A word shown on the A side |
| a_drive | output | 1 | A side driven (0 means high impedance) |

## Verification
The assertions assume the following about the inputs:
- Data and the qualifier are steady at every system-clock edge. The bench changes them only on the falling edge.
- The local clock and latch enable may change at any cycle. Only their synchronized copies steer the bank, and a clock rise is seen only if the local clock stays low for at least one sample and then high for at least one.

The random stimulus toggles the local clock, the qualifier and the output enable every cycle with even odds. The latch enable is held mostly low, so that clocked and held modes dominate and transparent stretches also occur. All inputs are applied from reset onward, so no assertion sees undriven values.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int NUM_DIRS = 2;

  typedef struct packed {
    logic le;
    logic lclk;
    logic ce_n;
    logic oe_n;
  } dir_ctrl_t;
endpackage

// File: rtl/xcvr_sync.sv
module xcvr_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= '0;
        else if (s == 0) stg[s] <= d;
        else stg[s] <= stg[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/xcvr_edge.sv
module xcvr_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise
);
  logic prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else prev <= lvl;
  end

  assign rise = lvl & ~prev;
endmodule

// File: rtl/xcvr_path.sv
module xcvr_path
  import xcvr_pkg::*;
#(
  parameter int DATA_W      = 18,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] din,
  input  dir_ctrl_t         ctl,
  output logic [DATA_W-1:0] dout,
  output logic              drive
);
  localparam int SW = 2;

  logic [SW-1:0]     sync_in, sync_out;
  logic              le_s, clk_s, rise;
  logic [DATA_W-1:0] store;
  logic              drv_q;

  assign sync_in = {ctl.le, ctl.lclk};

  xcvr_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(sync_in), .q(sync_out)
  );

  assign le_s  = sync_out[1];
  assign clk_s = sync_out[0];

  xcvr_edge u_edge (.clk(clk), .rst(rst), .lvl(clk_s), .rise(rise));

  // Latch enable wins; clocked capture needs a rise and the qualifier low.
  always_ff @(posedge clk) begin
    if (rst) store <= '0;
    else if (le_s) store <= din;
    else if (rise && !ctl.ce_n) store <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) drv_q <= 1'b0;
    else drv_q <= ~ctl.oe_n;
  end

  assign dout  = store;
  assign drive = drv_q;

  AST_TRANSPARENT_LOAD: assert property (@(posedge clk) disable iff (rst)
    le_s |=> (store == $past(din))); // R1
  AST_HOLD_NO_EDGE: assert property (@(posedge clk) disable iff (rst)
    (!le_s && !rise) |=> $stable(store)); // R2
  AST_CLOCKED_LOAD: assert property (@(posedge clk) disable iff (rst)
    (!le_s && rise && !ctl.ce_n) |=> (store == $past(din))); // R3
  AST_QUALIFIER_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (!le_s && ctl.ce_n) |=> $stable(store)); // R4
  AST_HIGHZ_ON_DISABLE: assert property (@(posedge clk) disable iff (rst)
    ctl.oe_n |=> !drive); // R5
  AST_DRIVE_ON_ENABLE: assert property (@(posedge clk) disable iff (rst)
    !ctl.oe_n |=> drive); // R5
endmodule

// File: rtl/bus_xcvr_top.sv
module bus_xcvr_top
  import xcvr_pkg::*;
#(
  parameter int DATA_W      = 18,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] a_in,
  input  logic [DATA_W-1:0] b_in,
  input  logic              ab_le,
  input  logic              ab_clk,
  input  logic              ab_ce_n,
  input  logic              ab_oe_n,
  input  logic              ba_le,
  input  logic              ba_clk,
  input  logic              ba_ce_n,
  input  logic              ba_oe_n,
  output logic [DATA_W-1:0] b_out,
  output logic              b_drive,
  output logic [DATA_W-1:0] a_out,
  output logic              a_drive
);
  // Index 0 carries A to B, index 1 carries B to A.
  dir_ctrl_t         ctl  [NUM_DIRS];
  logic [DATA_W-1:0] src  [NUM_DIRS];
  logic [DATA_W-1:0] dst  [NUM_DIRS];
  logic              drv  [NUM_DIRS];

  assign ctl[0] = '{le: ab_le, lclk: ab_clk, ce_n: ab_ce_n, oe_n: ab_oe_n};
  assign ctl[1] = '{le: ba_le, lclk: ba_clk, ce_n: ba_ce_n, oe_n: ba_oe_n};
  assign src[0] = a_in;
  assign src[1] = b_in;

  generate
    for (genvar d = 0; d < NUM_DIRS; d++) begin : g_dir
      xcvr_path #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_path (
        .clk(clk), .rst(rst), .din(src[d]), .ctl(ctl[d]),
        .dout(dst[d]), .drive(drv[d])
      );
    end
  endgenerate

  assign b_out   = dst[0];
  assign b_drive = drv[0];
  assign a_out   = dst[1];
  assign a_drive = drv[1];
endmodule

// File: tb/bus_xcvr_top_tb.sv
module bus_xcvr_top_tb;
  localparam int W = 18;
  localparam int MAX_CYC = 200000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic ab_le = 0, ab_clk = 0, ab_ce_n = 1, ab_oe_n = 1;
  logic ba_le = 0, ba_clk = 0, ba_ce_n = 1, ba_oe_n = 1;
  logic [W-1:0] a_out, b_out;
  logic a_drive, b_drive;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bus_xcvr_top #(.DATA_W(W)) u_dut (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
    .ab_le(ab_le), .ab_clk(ab_clk), .ab_ce_n(ab_ce_n), .ab_oe_n(ab_oe_n),
    .ba_le(ba_le), .ba_clk(ba_clk), .ba_ce_n(ba_ce_n), .ba_oe_n(ba_oe_n),
    .b_out(b_out), .b_drive(b_drive), .a_out(a_out), .a_drive(a_drive)
  );

  // Reference model: two-flop synchronizers, rise detection, then mode table.
  // Mode codes map to requirement tags: 1 R1, 2 R2, 3 R3, 4 R4, 7 R7, 8 R8.
  logic [1:0]   m_le [2], m_ck [2];
  logic         m_ckd [2];
  logic [W-1:0] m_q [2];
  logic         m_drv [2];
  logic         m_was_tr [2];
  int           m_mode [2];

  function automatic string tag_of(int m);
    case (m)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      4: return "R4";
      8: return "R8";
      default: return "R7";
    endcase
  endfunction

  task automatic model_dir(int d, logic le, logic ck, logic ce_n, logic oe_n,
                           logic [W-1:0] din);
    logic rise;
    rise = m_ck[d][1] & ~m_ckd[d];
    m_le[d]  <= {m_le[d][0], le};
    m_ck[d]  <= {m_ck[d][0], ck};
    m_ckd[d] <= m_ck[d][1];
    m_drv[d] <= ~oe_n;
    if (m_le[d][1]) begin
      m_q[d] <= din; m_mode[d] <= 1; m_was_tr[d] <= 1'b1;
    end else if (rise && !ce_n) begin
      m_q[d] <= din; m_mode[d] <= 3; m_was_tr[d] <= 1'b0;
    end else if (rise) begin
      m_mode[d] <= 4;
    end else begin
      m_mode[d] <= m_was_tr[d] ? 8 : 2;
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      for (int d = 0; d < 2; d++) begin
        m_le[d] <= '0; m_ck[d] <= '0; m_ckd[d] <= 1'b0; m_q[d] <= '0;
        m_drv[d] <= 1'b0; m_was_tr[d] <= 1'b0; m_mode[d] <= 7;
      end
    end else begin
      model_dir(0, ab_le, ab_clk, ab_ce_n, ab_oe_n, a_in);
      model_dir(1, ba_le, ba_clk, ba_ce_n, ba_oe_n, b_in);
    end
  end

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Every-cycle comparison against the model, sampled on the falling edge.
  always @(negedge clk) begin
    if (!done && m_mode[0] != 0) begin
      chk({tag_of(m_mode[0]), " A-to-B data"}, b_out, m_q[0]);
      chk({tag_of(m_mode[1]), " B-to-A data"}, a_out, m_q[1]);
      chk(rst ? "R7 B drive" : "R5 B drive", {{(W-1){1'b0}}, b_drive}, {{(W-1){1'b0}}, m_drv[0]});
      chk(rst ? "R7 A drive" : "R5 A drive", {{(W-1){1'b0}}, a_drive}, {{(W-1){1'b0}}, m_drv[1]});
    end
  end

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    for (int d = 0; d < 2; d++) m_mode[d] = 0;
    void'($urandom(32'd20240517));
    cyc(3);
    // R7: reset state
    chk("R7 reset B", b_out, '0);
    chk("R7 reset A", a_out, '0);
    rst = 1'b0;

    // R1 and R9: transparent, all ones on A-to-B, alternating on B-to-A (R6)
    a_in = '1; b_in = 18'h2AAAA; ab_le = 1; ba_le = 1;
    cyc(4);
    chk("R9 all ones", b_out, '1);
    chk("R6 both transparent", a_out, 18'h2AAAA);
    // R8: latch enable falls, later input changes are held off
    ab_le = 0; ba_le = 0;
    cyc(3);
    a_in = 18'h00F0F; b_in = 18'h15555;
    cyc(4);
    chk("R8 hold after fall", b_out, '1);
    chk("R8 hold after fall", a_out, 18'h2AAAA);
    // R4: qualifier high blocks a clock rise
    ab_ce_n = 1; ab_clk = 1;
    cyc(4);
    chk("R4 rise blocked", b_out, '1);
    ab_clk = 0; cyc(2);
    // R3 and R6: qualified rises in both directions at once
    ab_ce_n = 0; ba_ce_n = 0; ab_clk = 1; ba_clk = 1; ab_oe_n = 0; ba_oe_n = 0;
    cyc(4);
    chk("R3 clocked A-to-B", b_out, 18'h00F0F);
    chk("R6 clocked B-to-A", a_out, 18'h15555);
    chk("R5 drive on", {{(W-1){1'b0}}, b_drive}, 18'h1);
    // R4: qualifier ignored while transparent
    ab_ce_n = 1; ab_le = 1; a_in = 18'h12345;
    cyc(4);
    chk("R4 qualifier ignored when transparent", b_out, 18'h12345);
    ab_le = 0; cyc(3);

    // Random phase: qualifier toggled around local clock edges
    for (int i = 0; i < 4000; i++) begin
      a_in    = W'($urandom);
      b_in    = W'($urandom);
      ab_le   = ($urandom_range(0, 7) == 0);
      ba_le   = ($urandom_range(0, 7) == 0);
      ab_clk  = 1'($urandom);
      ba_clk  = 1'($urandom);
      ab_ce_n = 1'($urandom);
      ba_ce_n = 1'($urandom);
      ab_oe_n = 1'($urandom);
      ba_oe_n = 1'($urandom);
      if (i == 2000) rst = 1'b1;
      if (i == 2003) rst = 1'b0;
      cyc(1);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(MAX_CYC * 4);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule